// File: doc/BRIEF.md
# SPI Flash Block-Erase Sequencer

This block drives an external SPI serial flash so that one erase block is cleared to all ones. A single-cycle `start` pulse captures a 24-bit byte address and a size select. The sequencer then runs three kinds of chip-select frames in a fixed order:

- a write-enable instruction;
- the erase instruction with the block address, where the opcode depends on the chosen block size;
- repeated status reads, until the device reports that it is no longer busy.

It reports progress to the user through a `busy` level and a one-cycle `done` pulse. The serial link runs in clock mode 0. The serial clock comes from dividing the system clock by `CLK_DIV`. Chip select is held high for at least `CS_GAP` system clocks between frames. Releasing chip select after the erase frame is what starts the self-timed erase inside the device.

Top module: `spi_blk_erase`

## Requirements
- R1: After reset, `ce_n` is 1, `sck` is 0, and both `busy` and `done` are 0.
- R2: A `start` pulse while idle makes the first frame an 8-clock frame carrying opcode 0x06 (write enable).
- R3: The second frame carries opcode 0x52 when `size64` is 0 (32 KB block) and 0xD8 when `size64` is 1 (64 KB block).
- R4: The erase frame is 32 clocks long: 8 opcode bits, then 24 address bits, most significant bit first. Address bits 14..0 are sent as zero for a 32 KB erase. Address bits 15..0 are sent as zero for a 64 KB erase. The upper bits equal the captured address.
- R5: `ce_n` stays low for a whole frame and rises when the frame ends. Between frames it stays high for at least `CS_GAP` system clocks.
- R6: After the erase frame, 16-clock status frames with opcode 0x05 are repeated. Each frame reads a status byte on `so`, MSB first. Bit 0 of that byte means busy; the other bits are ignored. Polling stops after the first frame whose bit 0 reads 0.
- R7: `done` is high for exactly one system clock after the final status frame. `busy` falls in the same cycle and is high from the cycle after `start` until then.
- R8: A `start` pulse while `busy` is high is ignored. The frames on the bus and their address and opcode are unchanged, and only one `done` pulse follows.
- R9: The bus uses mode 0. `sck` is low whenever `ce_n` is high, and `si` changes only while `sck` is low. The controller samples `so` on the rising edge of `sck`.
- R10: Each high phase and each low phase of `sck` inside a frame lasts exactly `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to erase a block |
| size64 | input | 1 | 0 selects a 32 KB block, 1 selects a 64 KB block |
| addr | input | 24 | Byte address inside the block to erase |
| busy | output | 1 | High while an erase sequence is in progress |
| done | output | 1 | One-cycle pulse when the device reports not busy |
| sck | output | 1 | Serial clock to the flash |
| ce_n | output | 1 | Active-low chip select to the flash |
| si | output | 1 | Serial data to the flash |
| so | input | 1 | Serial data from the flash |

## Verification
Each result of this block appears a known number of cycles after its cause:

- `busy` is due one clock after `start`.
- A frame's chip select falls two clocks after the previous frame's gap ends.
- Each `sck` edge follows `CLK_DIV` clocks after the previous one.
- `done` appears at least `CS_GAP` clocks after chip select rises on the last status frame.

The bench does not predict absolute cycle numbers. It samples every output on the falling system clock edge and measures run lengths in clocks: the `sck` high phase, the `ce_n` high gap, and the width of the `done` pulse. A behavioural flash model decodes the frames at the `sck` and `ce_n` edges themselves. The bench compares the logged frames with the opcode, masked address and poll count it computed for each request, once `done` has been seen.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_ERASE32 = 8'h52;
  localparam logic [7:0] OP_ERASE64 = 8'hD8;
  localparam logic [7:0] OP_RDSR    = 8'h05;

  localparam int FRAME_W = 32;
  localparam int NB_W    = 6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WREN, SQ_ERASE, SQ_POLL} seq_state_t;
  typedef enum logic [1:0] {FR_IDLE, FR_RUN, FR_GAP} frame_state_t;
endpackage

// File: rtl/sck_tick.sv
module sck_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_erase_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fstart,
  input  logic [FRAME_W-1:0] tx,
  input  logic [NB_W-1:0]    nbits,
  input  logic               so,
  output logic               fdone,
  output logic               last_bit,
  output logic               sck,
  output logic               ce_n,
  output logic               si
);
  localparam int HW = $clog2(CS_GAP + 1);

  frame_state_t       st;
  logic [FRAME_W-1:0] sh;
  logic [NB_W-1:0]    cnt;
  logic [NB_W-1:0]    nb;
  logic [HW-1:0]      hi_cnt;
  logic               tick;

  sck_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (st == FR_RUN),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FR_IDLE;
      ce_n     <= 1'b1;
      sck      <= 1'b0;
      si       <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      nb       <= '0;
      last_bit <= 1'b0;
      fdone    <= 1'b0;
      hi_cnt   <= HW'(CS_GAP);
    end else begin
      fdone <= 1'b0;
      if (!ce_n)                      hi_cnt <= '0;
      else if (hi_cnt != HW'(CS_GAP)) hi_cnt <= hi_cnt + 1'b1;
      case (st)
        FR_IDLE: begin
          if (fstart) begin
            ce_n <= 1'b0;
            si   <= tx[FRAME_W-1];
            sh   <= {tx[FRAME_W-2:0], 1'b0};
            cnt  <= '0;
            nb   <= nbits;
            st   <= FR_RUN;
          end
        end
        FR_RUN: begin
          if (tick) begin
            if (!sck) begin
              sck      <= 1'b1;
              last_bit <= so;
            end else begin
              sck <= 1'b0;
              if (cnt == nb - 1'b1) begin
                ce_n <= 1'b1;
                st   <= FR_GAP;
              end else begin
                cnt <= cnt + 1'b1;
                si  <= sh[FRAME_W-1];
                sh  <= {sh[FRAME_W-2:0], 1'b0};
              end
            end
          end
        end
        FR_GAP: begin
          if (hi_cnt == HW'(CS_GAP - 1)) begin
            fdone <= 1'b1;
            st    <= FR_IDLE;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  a_r9_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> !sck);

  a_r9_si_hold_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(si));

  a_r5_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(ce_n) |-> ($past(hi_cnt) >= HW'(CS_GAP)));

  a_r5_cs_low_in_frame: assert property (@(posedge clk) disable iff (rst)
    (st == FR_RUN) |-> !ce_n);
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import spi_erase_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               size64,
  input  logic [23:0]        addr,
  input  logic               fdone,
  input  logic               last_bit,
  output logic               fstart,
  output logic [FRAME_W-1:0] tx,
  output logic [NB_W-1:0]    nbits,
  output logic               busy,
  output logic               done
);
  seq_state_t  st;
  logic [7:0]  op_q;
  logic [23:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      fstart <= 1'b0;
      tx     <= '0;
      nbits  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      fstart <= 1'b0;
      done   <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            op_q   <= size64 ? OP_ERASE64 : OP_ERASE32;
            addr_q <= size64 ? {addr[23:16], 16'h0000} : {addr[23:15], 15'h0000};
            tx     <= {OP_WREN, 24'h000000};
            nbits  <= NB_W'(8);
            fstart <= 1'b1;
            busy   <= 1'b1;
            st     <= SQ_WREN;
          end
        end
        SQ_WREN: begin
          if (fdone) begin
            tx     <= {op_q, addr_q};
            nbits  <= NB_W'(32);
            fstart <= 1'b1;
            st     <= SQ_ERASE;
          end
        end
        SQ_ERASE: begin
          if (fdone) begin
            tx     <= {OP_RDSR, 24'h000000};
            nbits  <= NB_W'(16);
            fstart <= 1'b1;
            st     <= SQ_POLL;
          end
        end
        SQ_POLL: begin
          if (fdone) begin
            if (last_bit) begin
              fstart <= 1'b1;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= SQ_IDLE;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(addr_q)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r2_launch_on_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && fstart));
endmodule

// File: rtl/spi_blk_erase.sv
module spi_blk_erase
  import spi_erase_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        size64,
  input  logic [23:0] addr,
  output logic        busy,
  output logic        done,
  output logic        sck,
  output logic        ce_n,
  output logic        si,
  input  logic        so
);
  logic               fstart;
  logic               fdone;
  logic               last_bit;
  logic [FRAME_W-1:0] tx;
  logic [NB_W-1:0]    nbits;

  erase_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .size64   (size64),
    .addr     (addr),
    .fdone    (fdone),
    .last_bit (last_bit),
    .fstart   (fstart),
    .tx       (tx),
    .nbits    (nbits),
    .busy     (busy),
    .done     (done)
  );

  spi_frame #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .fstart   (fstart),
    .tx       (tx),
    .nbits    (nbits),
    .so       (so),
    .fdone    (fdone),
    .last_bit (last_bit),
    .sck      (sck),
    .ce_n     (ce_n),
    .si       (si)
  );
endmodule

// File: tb/spi_blk_erase_test.sv
`timescale 1ns/1ps
module spi_blk_erase_test;
  localparam int DIV = 2;
  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        size64 = 1'b0;
  logic [23:0] addr = '0;
  logic        busy, done, sck, ce_n, si;
  logic        so = 1'b0;

  spi_blk_erase #(.CLK_DIV(DIV), .CS_GAP(GAP)) uut (
    .clk(clk), .rst(rst), .start(start), .size64(size64), .addr(addr),
    .busy(busy), .done(done), .sck(sck), .ce_n(ce_n), .si(si), .so(so)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural flash responder
  int          busy_polls = 0;
  int          busy_left  = 0;
  bit          wel = 0;
  int          bits = 0;
  logic [31:0] rsh = '0;
  logic [7:0]  cur_op = '0;
  int          nfr = 0;
  logic [7:0]  fr_op   [0:15];
  logic [23:0] fr_addr [0:15];
  int          fr_bits [0:15];

  always @(posedge sck or posedge ce_n) begin
    if (ce_n) begin
      if (bits > 0 && nfr < 16) begin
        logic [7:0] op;
        op = 8'((rsh >> (bits - 8)));
        fr_op[nfr]   = op;
        fr_addr[nfr] = (bits == 32) ? rsh[23:0] : 24'h0;
        fr_bits[nfr] = bits;
        nfr++;
        if (op == 8'h06 && bits == 8) wel = 1;
        if ((op == 8'h52 || op == 8'hD8) && bits == 32 && wel) begin
          busy_left = busy_polls;
          wel = 0;
        end
        if (op == 8'h05 && bits == 16 && busy_left > 0) busy_left--;
      end
      bits = 0;
      rsh  = '0;
    end else begin
      rsh = {rsh[30:0], si};
      bits++;
      if (bits == 8) cur_op = rsh[7:0];
    end
  end

  always @(negedge sck) begin
    if (!ce_n && bits >= 8 && bits < 16 && cur_op == 8'h05) begin
      logic [7:0] stat;
      stat = {7'b0001110, (busy_left > 0)};
      so <= stat[7 - (bits - 8)];
    end else begin
      so <= 1'b0;
    end
  end

  // protocol monitor sampled on the falling system clock edge
  logic p_sck = 0, p_si = 0, p_ce = 1, p_busy = 0;
  int   hi_run = 0, gap_run = 0, done_cnt = 0;
  bit   bad_half = 0, bad_hold = 0, bad_idle = 0, bad_gap = 0, bad_done = 0;
  int   cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (ce_n && sck) bad_idle = 1;
      if (sck && p_sck && si !== p_si) bad_hold = 1;
      if (sck) hi_run++;
      if (!sck && p_sck) begin
        if (hi_run != DIV) bad_half = 1;
        hi_run = 0;
      end
      if (ce_n) gap_run++;
      if (!ce_n && p_ce) begin
        if (gap_run < GAP) bad_gap = 1;
        gap_run = 0;
      end
      if (done) begin
        done_cnt++;
        if (busy || !p_busy) bad_done = 1;
      end
    end
    p_sck = sck; p_si = si; p_ce = ce_n; p_busy = busy;
  end

  task automatic run_op(input bit s64, input logic [23:0] a, input int polls, input bit inject);
    logic [23:0] exp_a;
    logic [7:0]  exp_op;
    int          wait_cnt;
    exp_a  = s64 ? {a[23:16], 16'h0} : {a[23:15], 15'h0};
    exp_op = s64 ? 8'hD8 : 8'h52;
    busy_polls = polls;
    nfr = 0; done_cnt = 0;
    bad_half = 0; bad_hold = 0; bad_idle = 0; bad_gap = 0; bad_done = 0;
    @(negedge clk); start = 1; size64 = s64; addr = a;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    if (inject) begin
      repeat (30) @(negedge clk);
      start = 1; size64 = !s64; addr = ~a;
      @(negedge clk); start = 0;
    end
    wait_cnt = 0;
    while (done_cnt == 0 && wait_cnt < 20000) begin
      @(posedge clk); wait_cnt++;
    end
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
    chk(!bad_done, "R7 done with busy falling", bad_done, 0);
    chk(nfr == polls + 3, inject ? "R8 frame count with ignored start" : "R6 frame count",
        nfr, polls + 3);
    chk(fr_op[0] == 8'h06 && fr_bits[0] == 8, "R2 write-enable frame", fr_op[0], 8'h06);
    chk(fr_op[1] == exp_op, inject ? "R8 opcode kept" : "R3 erase opcode", fr_op[1], exp_op);
    chk(fr_addr[1] == exp_a && fr_bits[1] == 32, inject ? "R8 address kept" : "R4 erase address",
        fr_addr[1], exp_a);
    for (int i = 2; i < nfr && i < 16; i++)
      chk(fr_op[i] == 8'h05 && fr_bits[i] == 16, "R6 status frame", fr_op[i], 8'h05);
    chk(!bad_gap, "R5 chip select gap", bad_gap, 0);
    chk(!bad_idle && !bad_hold, "R9 mode 0 timing", {bad_idle, bad_hold}, 0);
    chk(!bad_half, "R10 sck half period", bad_half, 0);
    chk(busy == 1'b0 && ce_n == 1'b1, "R7 idle after done", {busy, ce_n}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ce_n == 1 && sck == 0 && busy == 0 && done == 0, "R1 reset state",
        {ce_n, sck, busy, done}, 4'b1000);
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [23:0] a;
        a = (k == 0) ? 24'h000000 : (k == 1) ? 24'hFFFFFF : 24'(k * 24'h3C96D1);
        run_op(s[0], a, k % 3, 1'b0);
      end
    end
    run_op(1'b0, 24'h9ABCDE, 2, 1'b1);
    run_op(1'b1, 24'h13F7A5, 1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule